// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control and status front end of a successive-approximation analog-to-digital converter. It holds one 8-bit control/status register. Software writes it to pick an input channel, to enable the completion interrupt and to choose single or back-to-back conversion. The block issues one-cycle start requests to the external converter. It accepts a done pulse and a compare-true result in return, and from these it maintains the completion flag, the interrupt request and the converter's power enable.

A static mode input selects the launch source. In software mode, a register write starts conversion. In hardware mode, a rising edge on the trigger input starts it. Channel code 11111 means "off": writing it shuts the converter down, stops any continuous run and starts nothing new. A new start event during a conversion abandons that conversion, and the abandoned conversion never reports completion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `ctrl_q` reads 8'h1F: flag 0, interrupt enable 0, continuous enable 0, channel 11111. `conv_start`, `pwr_en` and `irq` are all 0.
- R2: A write loads the interrupt enable (bit 6), the continuous enable (bit 5) and the channel (bits 4:0) from `wr_data`. Bit 7 of `wr_data` is ignored because the flag cannot be written.
- R3: A completion is a `conv_done` pulse that arrives while a conversion is pending. A completion sets the flag (bit 7) when `cmp_en` is 0. When `cmp_en` is 1, it sets the flag only if `cmp_true` is 1 in that cycle.
- R4: A write or a `rd_lo` pulse clears the flag in the following cycle. If `rd_lo` and a flag-setting completion occur in the same cycle, the flag ends up set.
- R5: `irq` is high exactly while both the flag and the interrupt enable are set.
- R6: In software mode, with continuous enable 0, a write with a channel other than 11111 produces a single `conv_start` pulse in the next cycle. After that conversion completes, `pwr_en` falls in the next cycle and no further start follows.
- R7: With continuous enable 1, every completion produces a new `conv_start` in the next cycle, and `pwr_en` stays high. This repeats until a write stops it.
- R8: A write with channel 11111 issues no start and drops `pwr_en` in the next cycle. Any conversion in progress is abandoned, and a later `conv_done` for it has no effect.
- R9: In hardware mode, a write updates the fields and abandons any conversion, but starts nothing. A rising edge on `hw_trig` starts conversion when the channel is not 11111. A held-high trigger does not start again. In software mode, `hw_trig` is ignored.
- R10: A start event (write, or a trigger edge in hardware mode) during a conversion restarts it with the new settings. A `conv_done` in the same cycle as a start event is not a completion.
- R11: A `conv_done` while no conversion is pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_mode | input | 1 | Static launch source: 1 selects the hardware trigger, 0 selects register writes |
| cmp_en | input | 1 | Compare function enabled; gates the flag with `cmp_true` |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_lo | input | 1 | Strobe for a read of the low result byte; clears the flag |
| hw_trig | input | 1 | Hardware trigger level; starts conversion on its rising edge |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| cmp_true | input | 1 | Compare result, valid with `conv_done` |
| ctrl_q | output | 8 | Register readback {flag, irq enable, continuous, channel[4:0]} |
| conv_start | output | 1 | One-cycle start request to the converter |
| chan | output | 5 | Channel currently selected for the converter |
| pwr_en | output | 1 | Converter power enable; high while a conversion is pending |
| irq | output | 1 | Completion interrupt request |

## Verification
The assertions assume that `hw_mode` and `cmp_en` change only while no conversion is pending. They also assume that `conv_done` and `rd_lo` are single-cycle strobes that the environment may raise in any cycle, including while idle. The stimulus changes the static inputs only after waiting for `pwr_en` to fall or just after a channel-off write. It drives every other input at the falling edge, and it deliberately places done pulses in the same cycle as writes, result reads and trigger edges.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_mode,
  input  logic            cmp_en,
  input  logic            wr_en,
  input  logic [CH_W+2:0] wr_data,
  input  logic            rd_lo,
  input  logic            hw_trig,
  input  logic            conv_done,
  input  logic            cmp_true,
  output logic [CH_W+2:0] ctrl_q,
  output logic            conv_start,
  output logic [CH_W-1:0] chan,
  output logic            pwr_en,
  output logic            irq
);
  localparam int CEN_B = CH_W;
  localparam int IEN_B = CH_W + 1;
  localparam logic [CH_W-1:0] CH_OFF = '1;

  logic            flag_q, ien_q, cen_q, busy_q, run_q, start_q, trig_q;
  logic [CH_W-1:0] ch_q;

  logic [CH_W-1:0] ch_nxt;
  logic            cen_nxt, trig_edge, sw_go, hw_go, complete, launch, flag_set;

  assign ch_nxt    = wr_en ? wr_data[CH_W-1:0] : ch_q;
  assign cen_nxt   = wr_en ? wr_data[CEN_B] : cen_q;
  assign trig_edge = hw_mode & hw_trig & ~trig_q;
  assign sw_go     = wr_en & ~hw_mode & (ch_nxt != CH_OFF);
  assign hw_go     = trig_edge & ~wr_en & (ch_q != CH_OFF);
  assign complete  = conv_done & busy_q & ~wr_en & ~hw_go;
  assign launch    = sw_go | hw_go | (complete & run_q);
  assign flag_set  = complete & (~cmp_en | cmp_true);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      cen_q  <= 1'b0;
      ch_q   <= CH_OFF;
      trig_q <= 1'b0;
    end else begin
      trig_q <= hw_trig;
      if (wr_en) begin
        ien_q <= wr_data[IEN_B];
        cen_q <= wr_data[CEN_B];
        ch_q  <= wr_data[CH_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (flag_set)
      flag_q <= 1'b1;
    else if (wr_en || rd_lo)
      flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      run_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch;
      if (sw_go || hw_go) begin
        busy_q <= 1'b1;
        run_q  <= cen_nxt;
      end else if (wr_en) begin
        busy_q <= 1'b0;
        run_q  <= 1'b0;
      end else if (complete && !run_q) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign ctrl_q     = {flag_q, ien_q, cen_q, ch_q};
  assign conv_start = start_q;
  assign chan       = ch_q;
  assign pwr_en     = busy_q;
  assign irq        = flag_q & ien_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_mode,
  input logic       wr_en,
  input logic       rd_lo,
  input logic       conv_done,
  input logic [7:0] ctrl_q,
  input logic       conv_start,
  input logic       pwr_en
);
  assert_start_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> pwr_en);
  assert_off_chan_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (ctrl_q[4:0] != 5'h1F));
  assert_write_clears_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !ctrl_q[7]);
  assert_flag_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !$rose(ctrl_q[7]));
  assert_idle_done_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !pwr_en && !wr_en && !rd_lo) |=> $stable(ctrl_q[7]));
  assert_hw_write_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && wr_en) |=> !conv_start);
  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_lo && !conv_done) |=> $stable(ctrl_q[7]));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .wr_en(wr_en), .rd_lo(rd_lo),
  .conv_done(conv_done), .ctrl_q(ctrl_q), .conv_start(conv_start), .pwr_en(pwr_en)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_mode = 1'b0, cmp_en = 1'b0, wr_en = 1'b0, rd_lo = 1'b0, hw_trig = 1'b0;
  logic cmp_true = 1'b0, man_done = 1'b0, auto_done = 1'b0, auto_on = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic conv_done;
  logic [7:0] ctrl_q;
  logic [4:0] chan;
  logic conv_start, pwr_en, irq;
  int n_cmp = 0, n_bad = 0, cyc = 0, cnt = 0;
  string cur_req = "R1";

  // reference model state
  bit m_flag, m_ien, m_cen, m_busy, m_run, m_start, m_trig;
  bit [4:0] m_ch;

  assign conv_done = man_done | auto_done;
  always #5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .cmp_en(cmp_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_lo(rd_lo), .hw_trig(hw_trig), .conv_done(conv_done),
    .cmp_true(cmp_true), .ctrl_q(ctrl_q), .conv_start(conv_start), .chan(chan),
    .pwr_en(pwr_en), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_ien = 0; m_cen = 0; m_ch = 5'h1F;
      m_busy = 0; m_run = 0; m_start = 0; m_trig = 0;
    end else begin
      bit edge_go, comp, go;
      edge_go = hw_mode && hw_trig && !m_trig && !wr_en && (m_ch != 5'h1F);
      comp    = conv_done && m_busy && !wr_en && !edge_go;
      go      = 0;
      if (comp && (!cmp_en || cmp_true)) m_flag = 1;
      else if (wr_en || rd_lo) m_flag = 0;
      if (wr_en) begin
        m_ien = wr_data[6]; m_cen = wr_data[5]; m_ch = wr_data[4:0];
        if (!hw_mode && m_ch != 5'h1F) begin go = 1; m_busy = 1; m_run = m_cen; end
        else begin m_busy = 0; m_run = 0; end
      end else if (edge_go) begin
        go = 1; m_busy = 1; m_run = m_cen;
      end else if (comp) begin
        if (m_run) go = 1; else m_busy = 0;
      end
      m_start = go;
      m_trig  = hw_trig;
    end
  end

  // converter stand-in: done three cycles after the last start
  always @(negedge clk) begin
    auto_done = 1'b0;
    if (auto_on && rst_n) begin
      if (conv_start) cnt = 3;
      else if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) auto_done = 1'b1;
      end
    end else cnt = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic [7:0] e_ctrl;
      e_ctrl = {m_flag, m_ien, m_cen, m_ch};
      n_cmp++;
      if (ctrl_q !== e_ctrl || conv_start !== m_start || pwr_en !== m_busy ||
          irq !== (m_flag && m_ien) || chan !== m_ch) begin
        n_bad++;
        $display("FAIL %s cyc %0d: ctrl=%h start=%b pwr=%b irq=%b chan=%h exp ctrl=%h start=%b pwr=%b irq=%b",
                 cur_req, cyc, ctrl_q, conv_start, pwr_en, irq, chan,
                 e_ctrl, m_start, m_busy, m_flag && m_ien);
      end
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual cyc=%0d expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic done_pulse(logic c, logic rd);
    @(negedge clk); man_done = 1'b1; cmp_true = c; rd_lo = rd;
    @(negedge clk); man_done = 1'b0; cmp_true = 1'b0; rd_lo = 1'b0;
  endtask

  initial begin
    idle(2); rst_n = 1'b1;
    @(negedge clk); #1;
    n_cmp++;
    if (ctrl_q !== 8'h1F || conv_start || pwr_en || irq) begin
      n_bad++;
      $display("FAIL R1: ctrl=%h start=%b pwr=%b irq=%b exp 1f 0 0 0", ctrl_q, conv_start, pwr_en, irq);
    end
    cur_req = "R2 R8"; wr(8'hFF); idle(4);
    cur_req = "R6"; wr(8'h03); idle(8); wr(8'h84); idle(8);
    cur_req = "R3"; cmp_en = 1; auto_on = 0;
    wr(8'h05); idle(2); done_pulse(0, 0); idle(2);
    wr(8'h05); idle(2); done_pulse(1, 0); idle(2);
    cmp_en = 0;
    cur_req = "R4"; rd_lo = 1; @(negedge clk); rd_lo = 0; idle(2);
    cur_req = "R5"; wr(8'h42); idle(2); done_pulse(0, 0); idle(3); rd_lo = 1; @(negedge clk); rd_lo = 0;
    cur_req = "R4"; wr(8'h62); idle(2); done_pulse(0, 0); idle(2); done_pulse(0, 1); idle(2);
    cur_req = "R11"; wr(8'h1F); idle(2); done_pulse(0, 0); idle(2);
    cur_req = "R10"; wr(8'h06); idle(1); wr(8'h07); idle(1);
    @(negedge clk); wr_data = 8'h08; wr_en = 1; man_done = 1;
    @(negedge clk); wr_en = 0; man_done = 0; idle(2); done_pulse(0, 0); idle(2);
    cur_req = "R7"; auto_on = 1; wr(8'h25); idle(20);
    cur_req = "R8"; wr(8'h3F); idle(2);
    auto_on = 0; done_pulse(0, 0); idle(3); auto_on = 1;
    cur_req = "R9"; hw_trig = 1; idle(3); hw_trig = 0;
    idle(2); hw_mode = 1; wr(8'h07); idle(3);
    hw_trig = 1; idle(10); hw_trig = 0; idle(3);
    hw_trig = 1; @(negedge clk); hw_trig = 0; idle(8);
    wr(8'h29); hw_trig = 1; idle(16); hw_trig = 0;
    cur_req = "R10"; hw_trig = 1; @(negedge clk); hw_trig = 0; idle(2);
    auto_on = 0; @(negedge clk); hw_trig = 1; man_done = 1;
    @(negedge clk); hw_trig = 0; man_done = 0; auto_on = 1; idle(6);
    cur_req = "R9"; wr(8'h2A); idle(6);
    cur_req = "R8"; wr(8'h1F); idle(4); hw_mode = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule